// File: doc/BRIEF.md
# Multi-Stage Conversion Sequencer

This block drives a shared conversion engine through an ordered list of measurement stages. Each stage has its own input-selection word in a configuration table. While enabled, the sequencer starts at stage 0 and works upward. For each stage it puts that stage's word on the mux output, asks the engine for a conversion, waits for the done strobe and writes the returned value into the result slot of that stage. When the last stage is finished it raises a one-cycle end pulse. If the enable is still high it then starts again at stage 0.

The length of the sequence is set by a last-stage index: the value N runs stages 0 to N. The index is captured when each sequence starts. A thermometer mask marks the stages in use, so that per-stage features such as calibration can be enabled for exactly those stages. When the enable drops, the stage in flight completes and its result is written, and then the block goes idle.

Top module: `conv_stage_seq`

## Requirements
- R1: After reset, `conv_req`, `res_we` and `seq_end` are low and `mux_cfg` is zero.
- R2: Every sequence begins at stage 0, and stages are converted in ascending order with no gaps.
- R3: A last-stage value N runs stages 0 to N, which is N+1 conversions. A value above 11 is treated as 11.
- R4: While `conv_req` is high, `mux_cfg` equals the configuration word of the stage being converted. Stage k's word is `cfg_table[8k+7:8k]`.
- R5: `mux_cfg` carries the stage's word in the cycle before `conv_req` rises for that stage.
- R6: `conv_req` stays high until `conv_done` is sampled and is low in the following cycle. In that same following cycle `res_we` is high for exactly one cycle, with `res_idx` equal to the stage number and `res_data` equal to the `conv_data` sampled with `conv_done`.
- R7: `seq_end` is a one-cycle pulse in the cycle after the last stage's done, coincident with that stage's result write. If `seq_en` is high in that cycle, the next request is for stage 0.
- R8: Lowering `seq_en` during a conversion lets that conversion finish and write its result. After that no further request and no `seq_end` is issued.
- R9: `stage_mask` bit k is 1 exactly when k is at most the clamped last-stage input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_en | input | 1 | Run sequences while high |
| last_stage | input | 4 | Index of the final stage in a sequence |
| cfg_table | input | 96 | Twelve 8-bit per-stage mux words, stage k at bits 8k+7:8k |
| stage_mask | output | 12 | Thermometer mask of stages in use |
| mux_cfg | output | 8 | Mux word applied to the converter input |
| conv_req | output | 1 | Conversion request, held until done |
| conv_done | input | 1 | Conversion complete strobe |
| conv_data | input | 16 | Conversion result, valid with conv_done |
| res_we | output | 1 | Result write strobe |
| res_idx | output | 4 | Result slot (stage index) |
| res_data | output | 16 | Result value |
| seq_end | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions check the cycle-level handshake rules on every cycle. The request is held until done and dropped in the cycle after it, each done is followed by one write, and a request is always preceded by a setup cycle. The end pulse is a single cycle, written indices stay within the captured last stage, and the mask is a contiguous run from bit 0. Only the bench scenarios can show the rest against an independent model: the stage order, that each stage receives its own table word and its own result slot, the clamping of oversized lengths, the restart at stage 0 across back-to-back sequences, and the clean stop after the enable drops mid-sequence.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_SETUP = 2'd1,
    S_REQ   = 2'd2,
    S_END   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_s = sync_q;
endmodule

// File: rtl/seq_stage_mask.sv
module seq_stage_mask #(
  parameter int NSTG = 12,
  parameter int IDXW = 4
) (
  input  logic [IDXW-1:0] last_idx,
  output logic [NSTG-1:0] mask
);
  for (genvar k = 0; k < NSTG; k++) begin : g_bit
    assign mask[k] = (IDXW'(k) <= last_idx);
  end
endmodule

// File: rtl/seq_cfg_sel.sv
module seq_cfg_sel #(
  parameter int NSTG  = 12,
  parameter int CFG_W = 8,
  parameter int IDXW  = 4
) (
  input  logic [NSTG*CFG_W-1:0] table_in,
  input  logic [IDXW-1:0]       sel,
  output logic [CFG_W-1:0]      word
);
  always_comb begin
    word = '0;
    for (int k = 0; k < NSTG; k++) begin
      if (sel == IDXW'(k)) word = table_in[k*CFG_W +: CFG_W];
    end
  end
endmodule

// File: rtl/conv_stage_seq.sv
module conv_stage_seq
  import seq_pkg::*;
#(
  parameter int NSTG   = 12,
  parameter int CFG_W  = 8,
  parameter int DATA_W = 16,
  parameter int IDXW   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  seq_en,
  input  logic [IDXW-1:0]       last_stage,
  input  logic [NSTG*CFG_W-1:0] cfg_table,
  output logic [NSTG-1:0]       stage_mask,
  output logic [CFG_W-1:0]      mux_cfg,
  output logic                  conv_req,
  input  logic                  conv_done,
  input  logic [DATA_W-1:0]     conv_data,
  output logic                  res_we,
  output logic [IDXW-1:0]       res_idx,
  output logic [DATA_W-1:0]     res_data,
  output logic                  seq_end
);
  localparam logic [IDXW-1:0] MAX_IDX = IDXW'(NSTG - 1);

  logic rst_n_s;
  seq_state_e state_q, state_d;
  logic [IDXW-1:0] stage_q, stage_d;
  logic [IDXW-1:0] last_q, last_d;
  logic [IDXW-1:0] last_eff;
  logic            load_last;
  logic            cap_en;
  logic            we_q;
  logic [IDXW-1:0] idx_q;
  logic [DATA_W-1:0] data_q;
  logic [CFG_W-1:0]  cur_word;

  seq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  assign last_eff = (last_stage > MAX_IDX) ? MAX_IDX : last_stage;

  seq_stage_mask #(.NSTG(NSTG), .IDXW(IDXW)) u_mask (
    .last_idx(last_eff), .mask(stage_mask));

  seq_cfg_sel #(.NSTG(NSTG), .CFG_W(CFG_W), .IDXW(IDXW)) u_sel (
    .table_in(cfg_table), .sel(stage_q), .word(cur_word));

  // next-state logic
  always_comb begin
    state_d   = state_q;
    stage_d   = stage_q;
    load_last = 1'b0;
    cap_en    = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (seq_en) begin
          state_d   = S_SETUP;
          stage_d   = '0;
          load_last = 1'b1;
        end
      end
      S_SETUP: state_d = S_REQ;
      S_REQ: begin
        if (conv_done) begin
          cap_en = 1'b1;
          if (stage_q == last_q) begin
            state_d = S_END;
          end else if (seq_en) begin
            state_d = S_SETUP;
            stage_d = stage_q + 1'b1;
          end else begin
            state_d = S_IDLE;
          end
        end
      end
      S_END: begin
        if (seq_en) begin
          state_d   = S_SETUP;
          stage_d   = '0;
          load_last = 1'b1;
        end else begin
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
    last_d = load_last ? last_eff : last_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= S_IDLE;
      stage_q <= '0;
      last_q  <= '0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      stage_q <= stage_d;
      last_q  <= last_d;
      we_q    <= cap_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      idx_q  <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      idx_q  <= stage_q;
      data_q <= conv_data;
    end
  end

  assign conv_req = (state_q == S_REQ);
  assign seq_end  = (state_q == S_END);
  assign mux_cfg  = ((state_q == S_SETUP) || (state_q == S_REQ)) ? cur_word : '0;
  assign res_we   = we_q;
  assign res_idx  = idx_q;
  assign res_data = data_q;

  // assertions
  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == S_IDLE && seq_en) |=> (stage_q == '0));

  p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    res_we |-> (res_idx <= last_q && res_idx <= MAX_IDX));

  p_setup_first_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(conv_req) |-> ($past(state_q) == S_SETUP));

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (conv_req && !conv_done) |=> conv_req);

  p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (conv_req && conv_done) |=> (!conv_req && res_we));

  p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    res_we |=> !res_we);

  p_end_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    seq_end |=> !seq_end);

  p_end_with_write_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    seq_end |-> res_we);

  p_mask_contig_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    stage_mask[0] && ((stage_mask & (stage_mask + 1'b1)) == '0));
endmodule

// File: tb/conv_stage_seq_test.sv
module conv_stage_seq_test;
  localparam int NSTG = 12;
  localparam int CW   = 8;
  localparam int DW   = 16;

  typedef struct { int idx; logic [CW-1:0] cfg; } exp_t;
  typedef struct { int idx; logic [DW-1:0] data; } wr_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seq_en = 1'b0;
  logic [3:0] last_stage = 4'd0;
  logic [NSTG*CW-1:0] cfg_table = '0;
  logic [NSTG-1:0] stage_mask;
  logic [CW-1:0] mux_cfg;
  logic conv_req;
  logic conv_done = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic res_we;
  logic [3:0] res_idx;
  logic [DW-1:0] res_data;
  logic seq_end;

  conv_stage_seq uut (
    .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .last_stage(last_stage),
    .cfg_table(cfg_table), .stage_mask(stage_mask), .mux_cfg(mux_cfg),
    .conv_req(conv_req), .conv_done(conv_done), .conv_data(conv_data),
    .res_we(res_we), .res_idx(res_idx), .res_data(res_data), .seq_end(seq_end));

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  exp_t exp_q[$];
  wr_t  wr_q[$];
  int end_cnt = 0;
  int req_cnt = 0;
  int exp_last = 0;
  int last_wr_idx = -1;
  logic prev_req = 1'b0;
  logic prev_end = 1'b0;
  logic [CW-1:0] prev_mux = '0;
  logic busy = 1'b0;
  int cnt = 0;
  int lat_sel = 0;
  logic [DW-1:0] pend = '0;
  logic [DW-1:0] dgen = 16'h3A5C;
  logic [CW-1:0] cur_cfg = '0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // driver: push expected stage items for nseq sequences
  task automatic push_seq(input int last, input int nseq);
    int eff;
    eff = (last > 11) ? 11 : last;
    exp_last = eff;
    for (int s = 0; s < nseq; s++)
      for (int k = 0; k <= eff; k++) begin
        exp_t e;
        e.idx = k;
        e.cfg = cfg_table[k*CW +: CW];
        exp_q.push_back(e);
      end
  endtask

  task automatic fill_table(input int seed);
    for (int k = 0; k < NSTG; k++) cfg_table[k*CW +: CW] = CW'(seed + k * 37);
  endtask

  // responder + monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_req && !prev_req) begin
        req_cnt++;
        if (exp_q.size() == 0) begin
          chk(0, "R2", "unexpected request", 1, 0);
        end else begin
          exp_t e;
          wr_t w;
          e = exp_q.pop_front();
          chk(prev_mux == e.cfg, "R5", "mux word before request", prev_mux, e.cfg);
          cur_cfg = e.cfg;
          dgen = dgen * 16'd13 + 16'd7;
          pend = dgen;
          w.idx = e.idx;
          w.data = pend;
          wr_q.push_back(w);
        end
      end
      if (conv_req) chk(mux_cfg == cur_cfg, "R4", "mux word during request", mux_cfg, cur_cfg);
      if (conv_done) begin
        conv_done = 1'b0;
        busy = 1'b0;
      end else if (conv_req && !busy) begin
        busy = 1'b1;
        cnt = lat_sel;
        lat_sel = (lat_sel + 1) % 4;
        if (cnt == 0) begin conv_done = 1'b1; conv_data = pend; end
      end else if (busy) begin
        if (cnt <= 1) begin conv_done = 1'b1; conv_data = pend; end
        else cnt--;
      end
      if (res_we) begin
        if (wr_q.size() == 0) begin
          chk(0, "R6", "unexpected result write", res_idx, 0);
        end else begin
          wr_t w;
          w = wr_q.pop_front();
          chk(int'(res_idx) == w.idx, "R6", "result slot", res_idx, w.idx);
          chk(res_data == w.data, "R6", "result data", res_data, w.data);
          last_wr_idx = w.idx;
        end
      end
      if (seq_end) begin
        chk(!prev_end, "R7", "end pulse width", 1, 0);
        chk(res_we && last_wr_idx == exp_last, "R3", "last stage at end", last_wr_idx, exp_last);
        end_cnt++;
      end
      prev_end = seq_end;
      prev_req = conv_req;
      prev_mux = mux_cfg;
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_full(input int last, input int nseq, input int seed,
                          input logic [NSTG-1:0] exp_mask);
    int target;
    fill_table(seed);
    last_stage = 4'(last);
    @(negedge clk);
    chk(stage_mask == exp_mask, "R9", "stage mask", stage_mask, exp_mask);
    push_seq(last, nseq);
    target = end_cnt + nseq;
    seq_en = 1'b1;
    wait (end_cnt == target);
    seq_en = 1'b0;
    wait_cycles(10);
    chk(exp_q.size() == 0, "R3", "stages left unconverted", exp_q.size(), 0);
    chk(wr_q.size() == 0, "R6", "results not written", wr_q.size(), 0);
    chk(!conv_req, "R7", "idle after enable low", conv_req, 0);
  endtask

  initial begin
    int e0;
    wait_cycles(3);
    chk(!conv_req, "R1", "conv_req at reset", conv_req, 0);
    chk(!res_we, "R1", "res_we at reset", res_we, 0);
    chk(!seq_end, "R1", "seq_end at reset", seq_end, 0);
    chk(mux_cfg == '0, "R1", "mux_cfg at reset", mux_cfg, 0);
    rst_n = 1'b1;
    wait_cycles(4);
    chk(!conv_req && !res_we, "R1", "quiet after reset", conv_req, 0);

    run_full(5, 2, 8'h11, 12'h03F);   // R2 R7 restart at stage 0
    run_full(0, 3, 8'h5A, 12'h001);   // R3 single stage
    run_full(15, 1, 8'h90, 12'hFFF);  // R3 clamp
    run_full(11, 2, 8'h27, 12'hFFF);  // R3 full length, back to back
    last_stage = 4'd9;
    @(negedge clk);
    chk(stage_mask == 12'h3FF, "R9", "stage mask", stage_mask, 12'h3FF);

    // R8: drop enable during the third conversion
    fill_table(8'hC3);
    last_stage = 4'd11;
    e0 = end_cnt;
    for (int k = 0; k <= 2; k++) begin
      exp_t e;
      e.idx = k;
      e.cfg = cfg_table[k*CW +: CW];
      exp_q.push_back(e);
    end
    req_cnt = 0;
    seq_en = 1'b1;
    wait (req_cnt == 3);
    seq_en = 1'b0;
    wait_cycles(40);
    chk(exp_q.size() == 0 && wr_q.size() == 0, "R8", "in-flight stage finished", wr_q.size(), 0);
    chk(last_wr_idx == 2, "R8", "last written stage", last_wr_idx, 2);
    chk(req_cnt == 3, "R8", "no request after enable low", req_cnt, 3);
    chk(end_cnt == e0, "R8", "no end pulse", end_cnt, e0);
    chk(!conv_req, "R8", "conv_req low", conv_req, 0);
    report();
  end

  initial begin
    wait_cycles(50000);
    chk(0, "WDOG", "watchdog expired", 1, 0);
    report();
  end
endmodule